// File: doc/BRIEF.md
# Filtered Receive Frame Unpacker

This block sits behind a byte-level serial receiver and turns the incoming byte stream into frames. A frame opens with a three-byte header: sender address, target address, then payload length. The payload follows, and a two-byte checksum closes the frame. Every byte of a frame that is still being considered is written into a receive page at its offset within the frame. When the frame ends, the block either publishes the page or reports why it did not.

The checksum is the common 16-bit CRC used on industrial serial links. It starts from all ones and uses the reflected polynomial 0xA001. The checksum bytes are sent low byte first, so a clean frame leaves a zero residue. Which frames are kept is decided by an ordered address filter, applied when the target address byte arrives:

- a local address of 0xFF takes everything;
- otherwise, frames sent by the local address are dropped;
- broadcast, a match on either multicast register, or a match on the local address are accepted;
- everything else is dropped.

A pulse on the bus-idle input marks the end of traffic. If the pulse arrives before a frame is complete, the frame is broken. Broken frames can optionally be kept with an offset flag.

The controller is a single state machine with these states:

- `ST_SRC`: wait for the sender byte.
- `ST_DST`: filter decision on the target byte.
- `ST_LEN`: length check.
- `ST_DATA`: payload.
- `ST_CRC`: two checksum bytes.
- `ST_SKIP`: ignore bytes until bus idle.

Its transitions are:

- `ST_SRC`→`ST_DST` on any byte.
- `ST_DST`→`ST_LEN` when the frame is accepted and a page is free; `ST_DST`→`ST_SKIP` otherwise.
- `ST_LEN`→`ST_DATA` for a non-zero length, `ST_LEN`→`ST_CRC` for length zero, and `ST_LEN`→`ST_SKIP` for a length over the maximum.
- `ST_DATA`→`ST_CRC` after the last payload byte.
- `ST_CRC`→`ST_SKIP` after the second checksum byte.
- Any state other than `ST_SRC` returns to `ST_SRC` on bus idle.

A byte and an idle pulse in the same cycle: the byte wins.

Top module: `frame_unpacker`

## Requirements
- R1: Each byte taken in any state other than `ST_SKIP` while `page_free` is high is written one cycle later, with `wr_addr` equal to its offset in the frame (sender = 0, target = 1, length = 2, payload from 3).
- R2: When the second checksum byte of an accepted frame arrives and the CRC residue over all bytes is zero, `page_ready` pulses one cycle later with `page_flag` = 0. The CRC uses seed 0xFFFF and reflected polynomial 0xA001, and its low byte is sent first.
- R3: A complete accepted frame whose residue is non-zero pulses `err_broken` and does not pulse `page_ready`.
- R4: With `cfg_local_addr` = 0xFF, every frame is accepted, whatever its addresses.
- R5: With a local address other than 0xFF, a frame whose sender equals the local address is dropped, even when its target is 0xFF. No flag pulses.
- R6: A target of 0xFF from another sender is accepted as broadcast.
- R7: A target equal to a multicast register is accepted. A multicast register holding 0xFF never produces a match of its own.
- R8: A target equal to the local address is accepted as unicast. Any other target not covered above is dropped silently.
- R9: A length byte above 253 pulses `err_broken` and drops the frame. A length of 253 is accepted.
- R10: If bus idle arrives after an accepted target byte but before the frame is complete, `err_broken` pulses. When `cfg_keep_broken` is set, `page_ready` also pulses, with `page_flag` equal to the offset of the last byte received.
- R11: If bus idle arrives after only the sender byte, `err_broken` pulses and nothing is kept.
- R12: An accepted frame whose target byte arrives while `page_free` is low pulses `err_lost`, and is neither written nor published.
- R13: Bytes that follow a finished frame are ignored (no write, no flag) until bus idle.
- R14: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Received byte strobe |
| byte_in | input | 8 | Received byte |
| bus_idle | input | 1 | End-of-traffic pulse |
| page_free | input | 1 | An empty receive page is available |
| cfg_local_addr | input | 8 | Local address, 0xFF = take all |
| cfg_mcast | input | 16 | Two multicast addresses, 0xFF = unused |
| cfg_keep_broken | input | 1 | Keep truncated frames |
| wr_en | output | 1 | Page write strobe |
| wr_addr | output | 9 | Page write offset |
| wr_data | output | 8 | Page write byte |
| page_ready | output | 1 | Page published pulse |
| page_flag | output | 9 | 0 for a clean frame, else last byte offset |
| err_broken | output | 1 | Broken frame pulse |
| err_lost | output | 1 | No page for accepted frame pulse |

## Verification
Every result of this block comes from a register one cycle after the byte or idle pulse that causes it. This covers the write port, the ready pulse with its flag, and the broken and lost pulses. The bench's reference model updates its expectations at the same rising edge as the design. It compares the ports at the following falling edge, so each comparison lands in the cycle in which the result is due. Per-frame event counts are read only after the idle pulse has had two further cycles to take effect.

// File: rtl/frame_unpack_pkg.sv
package frame_unpack_pkg;

    localparam logic [7:0]  ADDR_ALL = 8'hFF;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'hA001;

    typedef enum logic [2:0] {
        ST_SRC,
        ST_DST,
        ST_LEN,
        ST_DATA,
        ST_CRC,
        ST_SKIP
    } rx_state_t;

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/frame_crc_unit.sv
module frame_crc_unit
    import frame_unpack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [15:0] crc_nxt
);
    logic [15:0] crc_q;

    always_comb begin
        crc_nxt = crc_byte(restart ? CRC_SEED : crc_q, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (step) begin
            crc_q <= crc_nxt;
        end
    end
endmodule

// File: rtl/frame_addr_filter.sv
module frame_addr_filter
    import frame_unpack_pkg::*;
#(
    parameter int NUM_MCAST = 2
) (
    input  logic [7:0]             local_addr,
    input  logic [NUM_MCAST*8-1:0] mcast,
    input  logic [7:0]             src,
    input  logic [7:0]             dst,
    output logic                   accept
);
    logic [NUM_MCAST-1:0] mc_hit;

    for (genvar g = 0; g < NUM_MCAST; g++) begin : g_mc
        assign mc_hit[g] = (mcast[g*8 +: 8] != ADDR_ALL) && (mcast[g*8 +: 8] == dst);
    end

    logic promisc, loopback, bcast, unicast;

    always_comb begin
        promisc  = (local_addr == ADDR_ALL);
        loopback = (src == local_addr);
        bcast    = (dst == ADDR_ALL);
        unicast  = (dst == local_addr);
        accept   = promisc || (!loopback && (bcast || (|mc_hit) || unicast));
    end
endmodule

// File: rtl/frame_unpacker.sv
module frame_unpacker
    import frame_unpack_pkg::*;
#(
    parameter int MAX_LEN   = 253,
    parameter int NUM_MCAST = 2,
    parameter int OFF_W     = $clog2(MAX_LEN + 5)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_vld,
    input  logic [7:0]             byte_in,
    input  logic                   bus_idle,
    input  logic                   page_free,
    input  logic [7:0]             cfg_local_addr,
    input  logic [NUM_MCAST*8-1:0] cfg_mcast,
    input  logic                   cfg_keep_broken,
    output logic                   wr_en,
    output logic [OFF_W-1:0]       wr_addr,
    output logic [7:0]             wr_data,
    output logic                   page_ready,
    output logic [OFF_W-1:0]       page_flag,
    output logic                   err_broken,
    output logic                   err_lost
);
    localparam logic [OFF_W-1:0] LAST_DATA_BIAS = OFF_W'(2);
    localparam logic [OFF_W-1:0] LAST_CRC_BIAS  = OFF_W'(4);
    localparam logic [7:0]       LEN_LIMIT      = 8'(MAX_LEN);

    rx_state_t        state, nxt;
    logic [OFF_W-1:0] cnt;
    logic [7:0]       len_q;
    logic [7:0]       src_q;
    logic [15:0]      crc_nxt;
    logic             accept;
    logic             idle_only;
    logic             last_data;
    logic             last_crc;

    assign idle_only = bus_idle && !byte_vld;
    assign last_data = (cnt == OFF_W'(len_q) + LAST_DATA_BIAS);
    assign last_crc  = (cnt == OFF_W'(len_q) + LAST_CRC_BIAS);

    frame_crc_unit u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state == ST_SRC),
        .step    (byte_vld && state != ST_SKIP),
        .din     (byte_in),
        .crc_nxt (crc_nxt)
    );

    frame_addr_filter #(.NUM_MCAST(NUM_MCAST)) u_filt (
        .local_addr (cfg_local_addr),
        .mcast      (cfg_mcast),
        .src        (src_q),
        .dst        (byte_in),
        .accept     (accept)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SRC: begin
                if (byte_vld) nxt = ST_DST;
            end
            ST_DST: begin
                if (byte_vld)       nxt = (accept && page_free) ? ST_LEN : ST_SKIP;
                else if (bus_idle)  nxt = ST_SRC;
            end
            ST_LEN: begin
                if (byte_vld) begin
                    if (byte_in > LEN_LIMIT)  nxt = ST_SKIP;
                    else if (byte_in == 8'd0) nxt = ST_CRC;
                    else                      nxt = ST_DATA;
                end else if (bus_idle) begin
                    nxt = ST_SRC;
                end
            end
            ST_DATA: begin
                if (byte_vld && last_data) nxt = ST_CRC;
                else if (idle_only)        nxt = ST_SRC;
            end
            ST_CRC: begin
                if (byte_vld && last_crc)  nxt = ST_SKIP;
                else if (idle_only)        nxt = ST_SRC;
            end
            ST_SKIP: begin
                if (idle_only) nxt = ST_SRC;
            end
            default: nxt = ST_SRC;
        endcase
    end

    // state register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SRC;
            cnt   <= '0;
            len_q <= '0;
            src_q <= '0;
        end else begin
            state <= nxt;
            if (byte_vld && state != ST_SKIP) begin
                cnt <= cnt + OFF_W'(1);
            end else if (idle_only) begin
                cnt <= '0;
            end
            if (byte_vld && state == ST_SRC) src_q <= byte_in;
            if (byte_vld && state == ST_LEN) len_q <= byte_in;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            page_ready <= 1'b0;
            page_flag  <= '0;
            err_broken <= 1'b0;
            err_lost   <= 1'b0;
        end else begin
            wr_en      <= byte_vld && page_free && (state != ST_SKIP);
            wr_addr    <= cnt;
            wr_data    <= byte_in;
            page_ready <= 1'b0;
            err_broken <= 1'b0;
            err_lost   <= 1'b0;
            unique case (state)
                ST_SRC: ;
                ST_DST: begin
                    if (byte_vld) begin
                        if (accept && !page_free) err_lost <= 1'b1;
                    end else if (bus_idle) begin
                        err_broken <= 1'b1;
                    end
                end
                ST_LEN, ST_DATA, ST_CRC: begin
                    if (byte_vld) begin
                        if (state == ST_LEN && byte_in > LEN_LIMIT) begin
                            err_broken <= 1'b1;
                        end
                        if (state == ST_CRC && last_crc) begin
                            if (crc_nxt == 16'h0000) begin
                                page_ready <= 1'b1;
                                page_flag  <= '0;
                            end else begin
                                err_broken <= 1'b1;
                            end
                        end
                    end else if (bus_idle) begin
                        err_broken <= 1'b1;
                        if (cfg_keep_broken) begin
                            page_ready <= 1'b1;
                            page_flag  <= cnt - OFF_W'(1);
                        end
                    end
                end
                ST_SKIP: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/frame_unpacker_chk.sv
module frame_unpacker_chk #(
    parameter int MAX_LEN = 253,
    parameter int OFF_W   = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_vld,
    input logic             cfg_keep_broken,
    input logic             wr_en,
    input logic [OFF_W-1:0] wr_addr,
    input logic             page_ready,
    input logic [OFF_W-1:0] page_flag,
    input logic             err_broken,
    input logic             err_lost
);
    // R1
    wr_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(byte_vld));

    // R9
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) <= MAX_LEN + 4));

    // R2
    clean_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_ready && page_flag == '0) |-> $past(byte_vld));

    // R3
    broken_not_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_broken |-> !(page_ready && page_flag == '0));

    // R10
    kept_broken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_ready && page_flag != '0) |-> ($past(cfg_keep_broken) && err_broken));

    // R12
    lost_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_lost |-> (!page_ready && !err_broken));
endmodule

bind frame_unpacker frame_unpacker_chk #(.MAX_LEN(MAX_LEN), .OFF_W(OFF_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .byte_vld        (byte_vld),
    .cfg_keep_broken (cfg_keep_broken),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .page_ready      (page_ready),
    .page_flag       (page_flag),
    .err_broken      (err_broken),
    .err_lost        (err_lost)
);

// File: tb/test_frame_unpacker.sv
`timescale 1ns/1ps
module test_frame_unpacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        bus_idle = 1'b0;
    logic        page_free = 1'b1;
    logic [7:0]  cfg_local_addr = 8'h0C;
    logic [15:0] cfg_mcast = 16'hFFFF;
    logic        cfg_keep_broken = 1'b0;
    logic        wr_en, page_ready, err_broken, err_lost;
    logic [8:0]  wr_addr, page_flag;
    logic [7:0]  wr_data;

    always #4 clk = ~clk;

    frame_unpacker i_frame_unpacker (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .bus_idle(bus_idle), .page_free(page_free), .cfg_local_addr(cfg_local_addr),
        .cfg_mcast(cfg_mcast), .cfg_keep_broken(cfg_keep_broken), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .page_ready(page_ready),
        .page_flag(page_flag), .err_broken(err_broken), .err_lost(err_lost)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) begin
            if (r[0]) r = (r >> 1) ^ 16'hA001;
            else      r = r >> 1;
        end
        return r;
    endfunction

    function automatic bit ref_accept(input logic [7:0] s, input logic [7:0] d);
        if (cfg_local_addr == 8'hFF) return 1;
        if (s == cfg_local_addr) return 0;
        if (d == 8'hFF) return 1;
        if (cfg_mcast[7:0] != 8'hFF && cfg_mcast[7:0] == d) return 1;
        if (cfg_mcast[15:8] != 8'hFF && cfg_mcast[15:8] == d) return 1;
        if (d == cfg_local_addr) return 1;
        return 0;
    endfunction

    // behavioural reference model, updated at each rising edge
    int          m_cnt, m_len;
    bit          m_skip;
    logic [15:0] m_crc;
    logic [7:0]  m_src;
    logic        e_wr, e_rdy, e_brk, e_lost;
    logic [8:0]  e_addr, e_flag;
    logic [7:0]  e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_len = 0; m_skip = 0; m_crc = 16'hFFFF; m_src = 0;
            e_wr <= 0; e_rdy <= 0; e_brk <= 0; e_lost <= 0;
            e_addr <= 0; e_data <= 0; e_flag <= 0;
        end else begin
            e_wr <= 0; e_rdy <= 0; e_brk <= 0; e_lost <= 0;
            if (byte_vld) begin
                if (!m_skip) begin
                    m_crc = ref_crc((m_cnt == 0) ? 16'hFFFF : m_crc, byte_in);
                    if (page_free) begin
                        e_wr <= 1; e_addr <= 9'(m_cnt); e_data <= byte_in;
                    end
                    if (m_cnt == 0) m_src = byte_in;
                    if (m_cnt == 1) begin
                        if (!ref_accept(m_src, byte_in)) m_skip = 1;
                        else if (!page_free) begin e_lost <= 1; m_skip = 1; end
                    end
                    if (m_cnt == 2) begin
                        if (byte_in > 253) begin e_brk <= 1; m_skip = 1; end
                        else m_len = byte_in;
                    end
                    if (m_cnt >= 3 && m_cnt == m_len + 4) begin
                        if (m_crc == 0) begin e_rdy <= 1; e_flag <= 0; end
                        else e_brk <= 1;
                        m_skip = 1;
                    end
                    m_cnt++;
                end
            end else if (bus_idle) begin
                if (!m_skip && m_cnt > 0) begin
                    e_brk <= 1;
                    if (m_cnt >= 2 && cfg_keep_broken) begin
                        e_rdy <= 1; e_flag <= 9'(m_cnt - 1);
                    end
                end
                m_cnt = 0; m_skip = 0;
            end
        end
    end

    // per-cycle comparison and event counting, away from the active edge
    int c_rdy, c_brk, c_lost, c_wr;
    logic [8:0] last_flag;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (wr_en !== e_wr || (e_wr && (wr_addr !== e_addr || wr_data !== e_data))) begin
                n_bad++;
                $display("FAIL R1 write: got %b/%0d/%h exp %b/%0d/%h", wr_en, wr_addr, wr_data, e_wr, e_addr, e_data);
            end
            n_cmp++;
            if (page_ready !== e_rdy || (e_rdy && page_flag !== e_flag)) begin
                n_bad++;
                $display("FAIL R2/R10 ready: got %b/%0d exp %b/%0d", page_ready, page_flag, e_rdy, e_flag);
            end
            n_cmp++;
            if (err_broken !== e_brk) begin
                n_bad++;
                $display("FAIL R3 broken: got %b exp %b", err_broken, e_brk);
            end
            n_cmp++;
            if (err_lost !== e_lost) begin
                n_bad++;
                $display("FAIL R12 lost: got %b exp %b", err_lost, e_lost);
            end
            c_rdy  += int'(page_ready);
            c_brk  += int'(err_broken);
            c_lost += int'(err_lost);
            c_wr   += int'(wr_en);
            if (page_ready) last_flag = page_flag;
        end
    end

    task automatic check_evt(input string tag, input int er, input int eb, input int el, input int ew);
        n_cmp++;
        if (c_rdy != er || c_brk != eb || c_lost != el || c_wr != ew) begin
            n_bad++;
            $display("FAIL %s events rdy/brk/lost/wr: got %0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d",
                     tag, c_rdy, c_brk, c_lost, c_wr, er, eb, el, ew);
        end
    endtask

    task automatic check_flag(input string tag, input logic [8:0] exp);
        n_cmp++;
        if (last_flag !== exp) begin
            n_bad++;
            $display("FAIL %s flag: got %0d exp %0d", tag, last_flag, exp);
        end
    endtask

    task automatic clear_evt();
        c_rdy = 0; c_brk = 0; c_lost = 0; c_wr = 0; last_flag = 9'h1FF;
    endtask

    // send a frame; trunc < 0 sends all of it, extra appends trailing bytes
    task automatic send_frame(input logic [7:0] s, input logic [7:0] d, input int len,
                              input bit corrupt, input int trunc, input int extra);
        logic [7:0]  q[$];
        logic [15:0] c = 16'hFFFF;
        int n;
        q.push_back(s); q.push_back(d); q.push_back(8'(len));
        for (int i = 0; i < len && len <= 253; i++) q.push_back(8'(i * 7 + len));
        foreach (q[i]) c = ref_crc(c, q[i]);
        q.push_back(c[7:0]); q.push_back(c[15:8]);
        if (corrupt) q[q.size() - 1] = q[q.size() - 1] ^ 8'h01;
        for (int i = 0; i < extra; i++) q.push_back(8'hA5);
        n = (trunc >= 0) ? trunc : q.size();
        clear_evt();
        for (int i = 0; i < n; i++) begin
            @(negedge clk); byte_vld = 1; byte_in = q[i];
            @(negedge clk); byte_vld = 0;
        end
        @(negedge clk); bus_idle = 1;
        @(negedge clk); bus_idle = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R14: reset state
        n_cmp++;
        if (wr_en || page_ready || err_broken || err_lost || page_flag != 0) begin
            n_bad++;
            $display("FAIL R14 reset outputs: got %b%b%b%b flag %0d exp 0000 flag 0",
                     wr_en, page_ready, err_broken, err_lost, page_flag);
        end
        // R8 unicast accepted, R1 write count, R2 clean flag
        send_frame(8'h0D, 8'h0C, 1, 0, -1, 0);
        check_evt("R8 unicast", 1, 0, 0, 6);
        check_flag("R2 clean", 9'd0);
        // R8 other target dropped; header bytes still written
        send_frame(8'h0D, 8'h22, 2, 0, -1, 0);
        check_evt("R8 drop", 0, 0, 0, 2);
        // R6 broadcast
        send_frame(8'h0D, 8'hFF, 3, 0, -1, 0);
        check_evt("R6 broadcast", 1, 0, 0, 8);
        // R5 loopback dropped even for broadcast
        send_frame(8'h0C, 8'hFF, 3, 0, -1, 0);
        check_evt("R5 loopback", 0, 0, 0, 2);
        // R7 multicast match on second register
        cfg_mcast = {8'hE5, 8'hE0};
        send_frame(8'h0D, 8'hE5, 2, 0, -1, 0);
        check_evt("R7 multicast", 1, 0, 0, 7);
        cfg_mcast = 16'hFFFF;
        send_frame(8'h0D, 8'hE5, 2, 0, -1, 0);
        check_evt("R7 disabled", 0, 0, 0, 2);
        // R4 promiscuous
        cfg_local_addr = 8'hFF;
        send_frame(8'h0C, 8'h33, 0, 0, -1, 0);
        check_evt("R4 promisc", 1, 0, 0, 5);
        cfg_local_addr = 8'h0C;
        // R3 bad checksum
        send_frame(8'h0D, 8'h0C, 4, 1, -1, 0);
        check_evt("R3 bad crc", 0, 1, 0, 9);
        // R9 over-long and maximum length
        send_frame(8'h0D, 8'h0C, 254, 0, -1, 0);
        check_evt("R9 too long", 0, 1, 0, 3);
        send_frame(8'h0D, 8'h0C, 253, 0, -1, 0);
        check_evt("R9 max len", 1, 0, 0, 258);
        // R10 truncated, kept
        cfg_keep_broken = 1;
        send_frame(8'h0D, 8'h0C, 6, 0, 5, 0);
        check_evt("R10 kept", 1, 1, 0, 5);
        check_flag("R10 offset", 9'd4);
        // R11 only sender byte, even with keep set
        send_frame(8'h0D, 8'h0C, 6, 0, 1, 0);
        check_evt("R11 one byte", 0, 1, 0, 1);
        cfg_keep_broken = 0;
        send_frame(8'h0D, 8'h0C, 6, 0, 5, 0);
        check_evt("R10 not kept", 0, 1, 0, 5);
        // R12 no free page
        page_free = 0;
        send_frame(8'h0D, 8'h0C, 2, 0, -1, 0);
        check_evt("R12 lost", 0, 0, 1, 0);
        page_free = 1;
        // R13 trailing bytes ignored
        send_frame(8'h0D, 8'h0C, 1, 0, -1, 3);
        check_evt("R13 trailing", 1, 0, 0, 6);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule